// File: doc/BRIEF.md
# Dual-Reload Timer with ON Counter

The block produces a pulse-width waveform from two separate reload values. A shared down-counter is loaded with the high-time value, counts down to zero, and is then loaded with the low-time value. When that also reaches zero the cycle repeats. Next to it runs an independent ON counter. This counter reloads itself from its own value each time it expires and signals each expiry with a one-cycle pulse. The ON counter can optionally be slowed by a divide-by-ten prescaler that never affects the waveform counter.

Both counters advance on one of two clock-enable inputs, fast or low-power, picked by a control bit. An output mode replaces the steady high level with the fast enable divided by two. Software sees four 16-bit registers: control, ON reload, high reload and low reload. Reading a reload address returns the live counter value instead of the stored reload.

Top module: `dual_reload_timer`

## Requirements
- R1: The ON, high and low reload values are each 16 bits wide. A high reload of 0xFFFF is read back as 0xFFFF on the first cycle of the high phase.
- R2: While control bit 0 is 0, the block is held idle. One cycle after bit 0 is cleared, the output is 0, both counters read 0 and the expiry pulse is 0.
- R3: Control bit 1 = 1 advances the counters on `fast_tick`; bit 1 = 0 advances them on `lp_tick`. The enable that is not selected has no effect on the counters.
- R4: Control bit 2 = 0 slows only the ON counter by ten. The high/low waveform timing is the same whatever bit 2 holds.
- R5: Control bit 3 = 0 drives the output at 1 for the whole high phase. With either setting the output is 0 for the whole low phase.
- R6: Register addresses are 0 = control, 1 = ON, 2 = high, 3 = low. Reading address 0 returns the control bits in [3:0]. Reading address 1 returns the live ON count. Reading address 2 or 3 returns the live high/low count.
- R7: After reset every register and counter reads 0, and the output and the expiry pulse are 0.
- R8: The cycle after the block is enabled, the high phase starts with the counter at the high reload. High lasts high+1 selected ticks, low lasts low+1 ticks, and the two alternate.
- R9: The ON counter is loaded from its reload at enable and decrements on each of its enables. On an enable at zero it reloads, and `on_expire` is 1 for exactly the following cycle.
- R10: With division active, the ON counter takes one step per ten selected ticks. Counting starts at enable.
- R11: With control bit 3 = 1, the output in each high phase starts at 0 and toggles on every `fast_tick`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fast_tick | input | 1 | Fast clock enable |
| lp_tick | input | 1 | Low-power clock enable |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data (live counts for addresses 1 to 3) |
| pwm_out | output | 1 | Waveform output |
| on_expire | output | 1 | One-cycle ON counter expiry pulse |

## Verification
A wrong phase bit or reload choice shows at `pwm_out` within one selected tick of the terminal count. It also shows at once in the live count read from address 2. A faulty prescaler or ON reload shifts the value read from address 1 on the first ON enable, and it moves the `on_expire` pulse off its expected cycle. A divider toggle that is not cleared inverts the first sample of the next high phase in clock-output mode.

// File: rtl/drt_pkg.sv
package drt_pkg;
  typedef enum logic [1:0] {
    ADR_CTRL = 2'd0,
    ADR_ON   = 2'd1,
    ADR_HIGH = 2'd2,
    ADR_LOW  = 2'd3
  } drt_addr_e;

  localparam int CTRL_W      = 4;
  localparam int BIT_RUN     = 0;
  localparam int BIT_FAST    = 1;
  localparam int BIT_NODIV   = 2;
  localparam int BIT_CLKOUT  = 3;
endpackage

// File: rtl/drt_prescale.sv
module drt_prescale #(
  parameter int DIV = 10,
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  input  logic          bypass,
  output logic          en_o,
  output logic [PW-1:0] pre_o
);
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  function automatic logic [PW-1:0] pre_next(input logic [PW-1:0] v);
    return (v == LAST) ? '0 : v + 1'b1;
  endfunction

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (clr)    pre_q <= '0;
    else if (tick)   pre_q <= pre_next(pre_q);
  end

  assign en_o  = tick && (bypass || (pre_q == LAST));
  assign pre_o = pre_q;
endmodule

// File: rtl/drt_phase_gen.sv
module drt_phase_gen #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         start,
  input  logic         tick,
  input  logic         fast_tick,
  input  logic         clkout_mode,
  input  logic [W-1:0] hi_rld,
  input  logic [W-1:0] lo_rld,
  output logic [W-1:0] cnt_o,
  output logic         high_o,
  output logic         toggle_o,
  output logic         pwm_o
);
  logic [W-1:0] cnt_q;
  logic         high_q;
  logic         tgl_q;

  function automatic logic [W-1:0] reload_for(input logic leaving_high,
                                               input logic [W-1:0] hi,
                                               input logic [W-1:0] lo);
    return leaving_high ? lo : hi;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      high_q <= 1'b0;
    end else if (!run) begin
      cnt_q  <= '0;
      high_q <= 1'b0;
    end else if (start) begin
      cnt_q  <= hi_rld;
      high_q <= 1'b1;
    end else if (tick) begin
      if (cnt_q == '0) begin
        cnt_q  <= reload_for(high_q, hi_rld, lo_rld);
        high_q <= !high_q;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  // divide-by-2 of the fast enable, held clear outside the high phase
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 tgl_q <= 1'b0;
    else if (!run || !high_q)   tgl_q <= 1'b0;
    else if (fast_tick)         tgl_q <= !tgl_q;
  end

  assign cnt_o    = cnt_q;
  assign high_o   = high_q;
  assign toggle_o = tgl_q;
  assign pwm_o    = high_q && (clkout_mode ? tgl_q : 1'b1);
endmodule

// File: rtl/drt_on_counter.sv
module drt_on_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         start,
  input  logic         en,
  input  logic [W-1:0] rld,
  output logic [W-1:0] cnt_o,
  output logic         expire_o
);
  logic [W-1:0] cnt_q;
  logic         exp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else if (!run) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else if (start) begin
      cnt_q <= rld;
      exp_q <= 1'b0;
    end else if (en) begin
      exp_q <= (cnt_q == '0);
      cnt_q <= (cnt_q == '0) ? rld : cnt_q - 1'b1;
    end else begin
      exp_q <= 1'b0;
    end
  end

  assign cnt_o    = cnt_q;
  assign expire_o = exp_q;
endmodule

// File: rtl/dual_reload_timer.sv
module dual_reload_timer #(
  parameter int DATA_W = 16,
  parameter int ON_DIV = 10,
  localparam int PW = (ON_DIV > 1) ? $clog2(ON_DIV) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fast_tick,
  input  logic              lp_tick,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              pwm_out,
  output logic              on_expire
);
  import drt_pkg::*;

  logic [CTRL_W-1:0] ctrl_q;
  logic [DATA_W-1:0] on_rld_q, hi_rld_q, lo_rld_q;
  logic              started_q;

  // named internal events
  logic              run, start_evt, sel_tick, on_en;
  logic [DATA_W-1:0] ph_cnt, on_cnt;
  logic              ph_high, ph_toggle;
  logic [PW-1:0]     pre_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      on_rld_q <= '0;
      hi_rld_q <= '0;
      lo_rld_q <= '0;
    end else if (reg_wr) begin
      unique case (drt_addr_e'(reg_addr))
        ADR_CTRL: ctrl_q   <= reg_wdata[CTRL_W-1:0];
        ADR_ON:   on_rld_q <= reg_wdata;
        ADR_HIGH: hi_rld_q <= reg_wdata;
        ADR_LOW:  lo_rld_q <= reg_wdata;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) started_q <= 1'b0;
    else        started_q <= run;
  end

  assign run       = ctrl_q[BIT_RUN];
  assign start_evt = run && !started_q;
  assign sel_tick  = ctrl_q[BIT_FAST] ? fast_tick : lp_tick;

  drt_prescale #(.DIV(ON_DIV)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (!run),
    .tick   (sel_tick),
    .bypass (ctrl_q[BIT_NODIV]),
    .en_o   (on_en),
    .pre_o  (pre_val)
  );

  drt_phase_gen #(.W(DATA_W)) u_phase (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run),
    .start       (start_evt),
    .tick        (sel_tick),
    .fast_tick   (fast_tick),
    .clkout_mode (ctrl_q[BIT_CLKOUT]),
    .hi_rld      (hi_rld_q),
    .lo_rld      (lo_rld_q),
    .cnt_o       (ph_cnt),
    .high_o      (ph_high),
    .toggle_o    (ph_toggle),
    .pwm_o       (pwm_out)
  );

  drt_on_counter #(.W(DATA_W)) u_on (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .start    (start_evt),
    .en       (on_en),
    .rld      (on_rld_q),
    .cnt_o    (on_cnt),
    .expire_o (on_expire)
  );

  always_comb begin
    unique case (drt_addr_e'(reg_addr))
      ADR_CTRL: reg_rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
      ADR_ON:   reg_rdata = on_cnt;
      default:  reg_rdata = ph_cnt;
    endcase
  end
endmodule

// File: rtl/drt_chk.sv
module drt_chk #(
  parameter int DATA_W = 16,
  parameter int ON_DIV = 10,
  localparam int PW = (ON_DIV > 1) ? $clog2(ON_DIV) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              started,
  input logic              tick,
  input logic              clkout_mode,
  input logic              nodiv,
  input logic              ph_high,
  input logic [DATA_W-1:0] ph_cnt,
  input logic [DATA_W-1:0] hi_rld,
  input logic [DATA_W-1:0] lo_rld,
  input logic              toggle,
  input logic              pwm,
  input logic              on_en,
  input logic [DATA_W-1:0] on_cnt,
  input logic [DATA_W-1:0] on_rld,
  input logic              on_expire,
  input logic [PW-1:0]     pre
);
  // R2
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!pwm && ph_cnt == '0 && on_cnt == '0 && !on_expire));

  // R8
  high_to_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && started && tick && ph_high && ph_cnt == '0) |=> (!ph_high && ph_cnt == $past(lo_rld)));

  // R8
  low_to_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && started && tick && !ph_high && ph_cnt == '0) |=> (ph_high && ph_cnt == $past(hi_rld)));

  // R5
  low_phase_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ph_high |-> !pwm);

  // R5
  steady_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_high && !clkout_mode) |-> pwm);

  // R11
  toggle_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ph_high) |-> !toggle);

  // R10
  prescale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (on_en && !nodiv) |-> (pre == PW'(ON_DIV - 1)));

  // R9
  expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && started && on_en && on_cnt == '0) |=> (on_expire && on_cnt == $past(on_rld)));
endmodule

bind dual_reload_timer drt_chk #(.DATA_W(DATA_W), .ON_DIV(ON_DIV)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .run         (run),
  .started     (started_q),
  .tick        (sel_tick),
  .clkout_mode (ctrl_q[3]),
  .nodiv       (ctrl_q[2]),
  .ph_high     (ph_high),
  .ph_cnt      (ph_cnt),
  .hi_rld      (hi_rld_q),
  .lo_rld      (lo_rld_q),
  .toggle      (ph_toggle),
  .pwm         (pwm_out),
  .on_en       (on_en),
  .on_cnt      (on_cnt),
  .on_rld      (on_rld_q),
  .on_expire   (on_expire),
  .pre         (pre_val)
);

// File: tb/dual_reload_timer_tb.sv
`timescale 1ns/1ps
module dual_reload_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fast_tick = 1'b0;
  logic        lp_tick = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        pwm_out;
  logic        on_expire;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dual_reload_timer u_dut (
    .clk(clk), .rst_n(rst_n), .fast_tick(fast_tick), .lp_tick(lp_tick),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pwm_out(pwm_out), .on_expire(on_expire)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // write completes at the next edge; returns at the negedge after it
  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'(a); reg_wdata = 16'(d);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    reg_addr = 2'(a);
    #1;
    v = int'(reg_rdata);
  endtask

  function automatic int on_exp(input int j, input int on, input bit div);
    int e;
    e = div ? (j / 10) : (j - 1);
    return on - (e % (on + 1));
  endfunction

  // Runs L samples after enabling with the fast enable always on
  task automatic run_cfg(input int m, input int n, input int on, input bit mode,
                         input bit div, input int len);
    int v, p, ctl;
    bit hi;
    wr(2, m); wr(3, n); wr(1, on);
    ctl = 1 | 2 | (div ? 0 : 4) | (mode ? 8 : 0);
    wr(0, ctl);
    for (int j = 1; j <= len; j++) begin
      @(negedge clk);
      p  = (j - 1) % (m + n + 2);
      hi = (p <= m);
      // R8 R5 R11 waveform, R4 timing independent of division
      chk(mode ? "R11" : (div ? "R4" : "R8"), "pwm", int'(pwm_out),
          hi ? (mode ? (p % 2) : 1) : 0);
      rd(2, v);
      chk("R6", "high addr count", v, hi ? (m - p) : (n - (p - m - 1)));
      rd(3, v);
      chk("R6", "low addr count", v, hi ? (m - p) : (n - (p - m - 1)));
      rd(1, v);
      chk(div ? "R10" : "R9", "on count", v, on_exp(j, on, div));
      chk("R9", "on_expire", int'(on_expire),
          (j >= 2 && (div ? (j % 10 == 0) : 1'b1) && on_exp(j - 1, on, div) == 0) ? 1 : 0);
    end
    // R2 disable returns everything to idle one cycle later
    wr(0, 0);
    @(negedge clk);
    chk("R2", "pwm off", int'(pwm_out), 0);
    chk("R2", "expire off", int'(on_expire), 0);
    rd(2, v); chk("R2", "phase count off", v, 0);
    rd(1, v); chk("R2", "on count off", v, 0);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7 reset state
    chk("R7", "pwm reset", int'(pwm_out), 0);
    chk("R7", "expire reset", int'(on_expire), 0);
    for (int a = 0; a < 4; a++) begin
      rd(a, v);
      chk("R7", "register reset", v, 0);
    end

    // R6 control readback
    wr(0, 16'h000E);
    rd(0, v); chk("R6", "ctrl readback", v, 14);
    wr(0, 0);

    fast_tick = 1'b1;
    // sweep of small reload values, modes and division
    for (int m = 0; m < 4; m++)
      for (int n = 0; n < 4; n++)
        run_cfg(m, n, (m + n) % 3, bit'((m + n) % 2), bit'(m % 2), 24);

    // R10 longer ON period with division
    run_cfg(2, 1, 2, 1'b0, 1'b1, 45);

    // R1 full-width reload value
    run_cfg(16'hFFFF, 0, 16'hFFFF, 1'b0, 1'b0, 5);

    // R3 low-power enable selected: same waveform from lp_tick
    fast_tick = 1'b0; lp_tick = 1'b1;
    wr(2, 2); wr(3, 1); wr(1, 3);
    wr(0, 1 | 4);
    for (int j = 1; j <= 12; j++) begin
      @(negedge clk);
      chk("R3", "lp pwm", int'(pwm_out), (((j - 1) % 5) <= 2) ? 1 : 0);
    end
    wr(0, 0);

    // R3 fast selected but only lp_tick toggles: counters must not move
    wr(0, 1 | 2 | 4);
    for (int j = 1; j <= 10; j++) begin
      @(negedge clk);
      chk("R3", "held pwm", int'(pwm_out), 1);
      rd(2, v); chk("R3", "held phase count", v, 2);
      rd(1, v); chk("R3", "held on count", v, 3);
    end
    wr(0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule